// File: doc/BRIEF.md
# Breakpoint Bitmap Store

This block holds eight independent breakpoint flags for every address the CPU can issue and checks them on each bus cycle. The flags for the current address are looked up, filtered by the breakpoint kinds software has enabled and by the kind of cycle (opcode fetch, data read or data write). A match raises a registered break indication one clock later. A matched spot flag on its own means "pause briefly and resume". Any other matched flag means "stop".

Addresses are resolved at two precisions. A small table of relocatable windows, each one block of `2**OFF_W` bytes, gives byte-exact flags. Every address outside all enabled windows shares one flag byte per block. A configuration port sets or clears a chosen set of flag bits over an inclusive address range. It is driven by a two-state walker: `W_IDLE` goes to `W_RUN` on a start request whose low bound is not above the high bound. `W_RUN` stays in `W_RUN` while it either writes the current address and advances, or holds for one clock when a temporary-flag clear needs the store. `W_RUN` returns to `W_IDLE` after the high bound has been written.

A fetch that matches an enabled temporary flag removes that flag from the entry it was read from. This lets step-over and return operations plant one-shot stops.

Top module: `bkpt_mem`

## Requirements
- R1: After reset every flag byte is zero, `cfg_busy`, `brk_halt`, `brk_spot` and `brk_hits` are zero, and no cycle produces a hit.
- R2: Inside an enabled window a flag is set on exactly one byte address; neighbouring bytes do not hit.
- R3: Outside all enabled windows a flag written at any address applies to every address of that address's block (`cpu_addr[ADDR_W-1:OFF_W]`), and to no other block.
- R4: The eight flag bits of an entry are independent: setting or clearing one bit through `cfg_mask` leaves the others unchanged.
- R5: Bit 0 (program), bit 1 (source line), bit 2 (spot) and bit 5 (temporary) match only on fetch cycles. Bit 3 matches only on reads and bit 4 only on writes. Bits 6 and 7 (user) match on fetch, read and write. The `cpu_kind` encoding is 0 fetch, 1 read, 2 write, 3 idle, and idle matches nothing.
- R6: A bit whose `bp_enable` bit is 0 never appears in `brk_hits`.
- R7: `brk_hits`, `brk_halt` and `brk_spot` are valid the clock after the cycle. `brk_spot` is 1 only when the sole matched bit is bit 2. `brk_halt` is 1 when any matched bit other than bit 2 is present. The two are never 1 together.
- R8: A fetch that matches an enabled bit 5 clears bit 5 of the entry it was read from (fine or block entry) and leaves the entry's other bits unchanged.
- R9: After a start with `cfg_lo <= cfg_hi`, `cfg_busy` is 1 for exactly `cfg_hi - cfg_lo + 1` clocks when no temporary clear intervenes. Every address in the range is set (`cfg_set`=1) or cleared (`cfg_set`=0) in the bits of `cfg_mask`.
- R10: A start with `cfg_lo > cfg_hi`, or a start while `cfg_busy` is 1, is ignored and changes no flag.
- R11: Writing window `win_sel` with `win_on`=1 makes block `win_blk` byte-precise and hides that block's shared byte. With `win_on`=0 the shared byte applies again. Window writes while `cfg_busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | A CPU cycle is present this clock |
| cpu_kind | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write, 3 idle |
| cpu_addr | input | ADDR_W | Cycle address |
| bp_enable | input | 8 | Per-bit enable of breakpoint kinds |
| cfg_start | input | 1 | Start a range set or clear |
| cfg_set | input | 1 | 1 sets, 0 clears the masked bits |
| cfg_mask | input | 8 | Bits to modify |
| cfg_lo | input | ADDR_W | First address of the range |
| cfg_hi | input | ADDR_W | Last address of the range, inclusive |
| cfg_busy | output | 1 | Range walk in progress |
| win_we | input | 1 | Write one window table entry |
| win_sel | input | WSEL_W | Window index |
| win_blk | input | ADDR_W-OFF_W | Block the window covers |
| win_on | input | 1 | Window enabled |
| brk_halt | output | 1 | Stopping breakpoint matched on the previous cycle |
| brk_spot | output | 1 | Only a spot breakpoint matched on the previous cycle |
| brk_hits | output | 8 | Matched bits of the previous cycle |

## Verification
The assertions assume that `cpu_valid` and `cpu_kind` are driven to known values at every clock after reset. They also assume that window entries never overlap in a way a check depends on, since the lowest-numbered window wins. The bench drives every input from the falling edge and holds `cpu_valid` low between probes. It configures windows only over distinct blocks. It never starts a range walk while a fetch could clear a temporary flag, so the busy-length check sees an uninterrupted walk.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int NBITS     = 8;
    localparam int BIT_PROG  = 0;
    localparam int BIT_LINE  = 1;
    localparam int BIT_SPOT  = 2;
    localparam int BIT_RD    = 3;
    localparam int BIT_WR    = 4;
    localparam int BIT_TEMP  = 5;
    localparam int BIT_USR0  = 6;
    localparam int BIT_USR1  = 7;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_IDLE  = 2'd3
    } cyc_kind_e;

    typedef logic [NBITS-1:0] flags_t;

    localparam flags_t USER_BITS  = flags_t'((1 << BIT_USR0) | (1 << BIT_USR1));
    localparam flags_t FETCH_BITS = flags_t'((1 << BIT_PROG) | (1 << BIT_LINE) |
                                             (1 << BIT_SPOT) | (1 << BIT_TEMP)) | USER_BITS;
    localparam flags_t READ_BITS  = flags_t'(1 << BIT_RD) | USER_BITS;
    localparam flags_t WRITE_BITS = flags_t'(1 << BIT_WR) | USER_BITS;

    function automatic flags_t kind_mask(input cyc_kind_e k);
        flags_t m;
        unique case (k)
            K_FETCH: m = FETCH_BITS;
            K_READ:  m = READ_BITS;
            K_WRITE: m = WRITE_BITS;
            K_IDLE:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bkpt_win_map.sv
module bkpt_win_map #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int NWIN   = 4,
    localparam int BLKN_W = ADDR_W - OFF_W,
    localparam int WSEL_W = $clog2(NWIN),
    localparam int FIDX_W = WSEL_W + OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frozen,
    input  logic                        we,
    input  logic [WSEL_W-1:0]           sel,
    input  logic [BLKN_W-1:0]           blk,
    input  logic                        on,
    input  logic [1:0][ADDR_W-1:0]      look_addr,
    output logic [1:0]                  look_fine,
    output logic [1:0][FIDX_W-1:0]      look_fidx,
    output logic [1:0][BLKN_W-1:0]      look_cidx
);

    logic [BLKN_W-1:0] win_blk_q [NWIN];
    logic [NWIN-1:0]   win_on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_on_q <= '0;
            for (int w = 0; w < NWIN; w++) win_blk_q[w] <= '0;
        end else if (we && !frozen) begin
            win_on_q[sel]  <= on;
            win_blk_q[sel] <= blk;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic              hit;
        logic [WSEL_W-1:0] wsel;
        always_comb begin
            hit  = 1'b0;
            wsel = '0;
            for (int w = NWIN - 1; w >= 0; w--) begin
                if (win_on_q[w] && win_blk_q[w] == look_addr[p][ADDR_W-1:OFF_W]) begin
                    hit  = 1'b1;
                    wsel = w[WSEL_W-1:0];
                end
            end
        end
        assign look_fine[p] = hit;
        assign look_fidx[p] = {wsel, look_addr[p][OFF_W-1:0]};
        assign look_cidx[p] = look_addr[p][ADDR_W-1:OFF_W];
    end

    AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(win_on_q)); // R11

endmodule

// File: rtl/bkpt_store.sv
module bkpt_store
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int NWIN   = 4,
    localparam int BLKN_W = ADDR_W - OFF_W,
    localparam int WSEL_W = $clog2(NWIN),
    localparam int FIDX_W = WSEL_W + OFF_W,
    localparam int FINE_N = NWIN << OFF_W,
    localparam int BLK_N  = 1 << BLKN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fine,
    input  logic [FIDX_W-1:0] rd_fidx,
    input  logic [BLKN_W-1:0] rd_cidx,
    output flags_t            rd_data,
    input  logic              tc_en,
    input  logic              tc_fine,
    input  logic [FIDX_W-1:0] tc_fidx,
    input  logic [BLKN_W-1:0] tc_cidx,
    input  logic              wk_en,
    input  logic              wk_fine,
    input  logic [FIDX_W-1:0] wk_fidx,
    input  logic [BLKN_W-1:0] wk_cidx,
    input  logic              wk_set,
    input  flags_t            wk_mask
);

    flags_t fine_q   [FINE_N];
    flags_t coarse_q [BLK_N];
    flags_t wk_old;
    flags_t wk_new;

    assign rd_data = rd_fine ? fine_q[rd_fidx] : coarse_q[rd_cidx];
    assign wk_old  = wk_fine ? fine_q[wk_fidx] : coarse_q[wk_cidx];
    assign wk_new  = wk_set ? (wk_old | wk_mask) : (wk_old & ~wk_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FINE_N; i++) fine_q[i] <= '0;
            for (int j = 0; j < BLK_N; j++) coarse_q[j] <= '0;
        end else if (tc_en) begin
            if (tc_fine) fine_q[tc_fidx][BIT_TEMP]   <= 1'b0;
            else         coarse_q[tc_cidx][BIT_TEMP] <= 1'b0;
        end else if (wk_en) begin
            if (wk_fine) fine_q[wk_fidx]   <= wk_new;
            else         coarse_q[wk_cidx] <= wk_new;
        end
    end

    AST_TEMP_FINE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_en && tc_fine) |=> !fine_q[$past(tc_fidx)][BIT_TEMP]); // R8
    AST_TEMP_BLK_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_en && !tc_fine) |=> !coarse_q[$past(tc_cidx)][BIT_TEMP]); // R8

endmodule

// File: rtl/bkpt_walk_fsm.sv
module bkpt_walk_fsm
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              set,
    input  flags_t            mask,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              hold,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_set,
    output flags_t            wr_mask
);

    typedef enum logic {W_IDLE, W_RUN} walk_st_e;

    walk_st_e          st_q, st_d;
    logic [ADDR_W-1:0] cur_q, hi_q;
    logic              set_q;
    flags_t            mask_q;
    logic              accept;
    logic              last;

    assign accept = (st_q == W_IDLE) && start && (lo <= hi);
    assign last   = (cur_q == hi_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE: if (accept)        st_d = W_RUN;
            W_RUN:  if (!hold && last) st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= W_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            hi_q   <= '0;
            set_q  <= 1'b0;
            mask_q <= '0;
        end else if (accept) begin
            cur_q  <= lo;
            hi_q   <= hi;
            set_q  <= set;
            mask_q <= mask;
        end else if (st_q == W_RUN && !hold && !last) begin
            cur_q <= cur_q + 1'b1;
        end
    end

    always_comb begin
        busy    = 1'b0;
        wr_en   = 1'b0;
        unique case (st_q)
            W_IDLE: ;
            W_RUN: begin
                busy  = 1'b1;
                wr_en = !hold;
            end
        endcase
        wr_addr = cur_q;
        wr_set  = set_q;
        wr_mask = mask_q;
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start && lo <= hi)); // R10
    AST_CUR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cur_q <= hi_q); // R9

endmodule

// File: rtl/bkpt_mem.sv
module bkpt_mem
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int NWIN   = 4,
    localparam int BLKN_W = ADDR_W - OFF_W,
    localparam int WSEL_W = $clog2(NWIN),
    localparam int FIDX_W = WSEL_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_kind,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        bp_enable,
    input  logic              cfg_start,
    input  logic              cfg_set,
    input  logic [7:0]        cfg_mask,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    output logic              cfg_busy,
    input  logic              win_we,
    input  logic [WSEL_W-1:0] win_sel,
    input  logic [BLKN_W-1:0] win_blk,
    input  logic              win_on,
    output logic              brk_halt,
    output logic              brk_spot,
    output logic [7:0]        brk_hits
);

    localparam flags_t SPOT_ONLY = flags_t'(1 << BIT_SPOT);

    logic [1:0][ADDR_W-1:0] look_addr;
    logic [1:0]             look_fine;
    logic [1:0][FIDX_W-1:0] look_fidx;
    logic [1:0][BLKN_W-1:0] look_cidx;

    logic              wk_en, wk_set;
    logic [ADDR_W-1:0] wk_addr;
    flags_t            wk_mask;
    flags_t            entry;
    flags_t            hit;
    logic              tc_en;

    flags_t hits_q;
    logic   halt_q, spot_q;

    assign look_addr = {wk_addr, cpu_addr};

    bkpt_win_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NWIN(NWIN)) map_i (
        .clk(clk), .rst_n(rst_n), .frozen(cfg_busy),
        .we(win_we), .sel(win_sel), .blk(win_blk), .on(win_on),
        .look_addr(look_addr), .look_fine(look_fine),
        .look_fidx(look_fidx), .look_cidx(look_cidx)
    );

    bkpt_walk_fsm #(.ADDR_W(ADDR_W)) walk_i (
        .clk(clk), .rst_n(rst_n), .start(cfg_start), .set(cfg_set),
        .mask(cfg_mask), .lo(cfg_lo), .hi(cfg_hi), .hold(tc_en),
        .busy(cfg_busy), .wr_en(wk_en), .wr_addr(wk_addr),
        .wr_set(wk_set), .wr_mask(wk_mask)
    );

    bkpt_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NWIN(NWIN)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_fine(look_fine[0]), .rd_fidx(look_fidx[0]), .rd_cidx(look_cidx[0]),
        .rd_data(entry),
        .tc_en(tc_en), .tc_fine(look_fine[0]), .tc_fidx(look_fidx[0]),
        .tc_cidx(look_cidx[0]),
        .wk_en(wk_en), .wk_fine(look_fine[1]), .wk_fidx(look_fidx[1]),
        .wk_cidx(look_cidx[1]), .wk_set(wk_set), .wk_mask(wk_mask)
    );

    always_comb begin
        hit = '0;
        if (cpu_valid) hit = entry & bp_enable & kind_mask(cyc_kind_e'(cpu_kind));
    end

    assign tc_en = hit[BIT_TEMP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits_q <= '0;
            halt_q <= 1'b0;
            spot_q <= 1'b0;
        end else begin
            hits_q <= hit;
            halt_q <= |(hit & ~SPOT_ONLY);
            spot_q <= (hit == SPOT_ONLY);
        end
    end

    assign brk_hits = hits_q;
    assign brk_halt = halt_q;
    assign brk_spot = spot_q;

    AST_SPOT_EXCL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_halt && brk_spot)); // R7
    AST_HITS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (brk_hits & ~$past(bp_enable)) == '0); // R6
    AST_RD_BIT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!brk_hits[BIT_RD] || $past(cpu_kind) == K_READ)); // R5
    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> brk_hits == '0); // R5

endmodule

// File: tb/bkpt_mem_tb.sv
module bkpt_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [1:0]  cpu_kind = 2'd3;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  bp_enable = '0;
    logic        cfg_start = 1'b0;
    logic        cfg_set = 1'b0;
    logic [7:0]  cfg_mask = '0;
    logic [15:0] cfg_lo = '0;
    logic [15:0] cfg_hi = '0;
    logic        cfg_busy;
    logic        win_we = 1'b0;
    logic [1:0]  win_sel = '0;
    logic [7:0]  win_blk = '0;
    logic        win_on = 1'b0;
    logic        brk_halt, brk_spot;
    logic [7:0]  brk_hits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // kind, enable, expected hits, expected halt, expected spot (entry 0xDF)
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd0, 8'hFF, 8'hC7, 1'b1, 1'b0},
        {2'd1, 8'hFF, 8'hC8, 1'b1, 1'b0},
        {2'd2, 8'hFF, 8'hD0, 1'b1, 1'b0},
        {2'd3, 8'hFF, 8'h00, 1'b0, 1'b0},
        {2'd0, 8'h04, 8'h04, 1'b0, 1'b1},
        {2'd0, 8'h08, 8'h00, 1'b0, 1'b0},
        {2'd1, 8'h07, 8'h00, 1'b0, 1'b0},
        {2'd2, 8'h40, 8'h40, 1'b1, 1'b0},
        {2'd0, 8'h06, 8'h06, 1'b1, 1'b0},
        {2'd0, 8'h00, 8'h00, 1'b0, 1'b0},
        {2'd1, 8'h10, 8'h00, 1'b0, 1'b0},
        {2'd2, 8'h08, 8'h00, 1'b0, 1'b0}
    };

    bkpt_mem dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_kind(cpu_kind),
        .cpu_addr(cpu_addr), .bp_enable(bp_enable), .cfg_start(cfg_start),
        .cfg_set(cfg_set), .cfg_mask(cfg_mask), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_busy(cfg_busy), .win_we(win_we), .win_sel(win_sel), .win_blk(win_blk),
        .win_on(win_on), .brk_halt(brk_halt), .brk_spot(brk_spot), .brk_hits(brk_hits)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: hits/halt/spot actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [1:0] k, input logic [15:0] a,
                         input logic [7:0] en, input logic [7:0] eh,
                         input logic ehalt, input logic espot);
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_kind  = k;
        cpu_addr  = a;
        bp_enable = en;
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_kind  = 2'd3;
        chk(req, {brk_hits, brk_halt, brk_spot}, {eh, ehalt, espot});
    endtask

    task automatic walk(input logic s, input logic [7:0] m, input logic [15:0] lo,
                        input logic [15:0] hi, output int busy_cycles);
        @(negedge clk);
        cfg_start = 1'b1;
        cfg_set   = s;
        cfg_mask  = m;
        cfg_lo    = lo;
        cfg_hi    = hi;
        @(negedge clk);
        cfg_start = 1'b0;
        busy_cycles = 0;
        while (cfg_busy) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic set_win(input logic [1:0] w, input logic [7:0] b, input logic on);
        @(negedge clk);
        win_we  = 1'b1;
        win_sel = w;
        win_blk = b;
        win_on  = on;
        @(negedge clk);
        win_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {brk_hits, brk_halt, brk_spot}, 10'd0);
        chk("R1", {9'd0, cfg_busy}, 10'd0);
        rst_n = 1'b1;
        probe("R1", 2'd0, 16'h1234, 8'hFF, 8'h00, 1'b0, 1'b0);

        set_win(2'd0, 8'h12, 1'b1);

        // R2: byte precision inside a window
        walk(1'b1, 8'h01, 16'h1234, 16'h1234, n);
        probe("R2", 2'd0, 16'h1234, 8'hFF, 8'h01, 1'b1, 1'b0);
        probe("R2", 2'd0, 16'h1235, 8'hFF, 8'h00, 1'b0, 1'b0);
        probe("R2", 2'd0, 16'h1233, 8'hFF, 8'h00, 1'b0, 1'b0);

        // R3: block precision outside windows
        walk(1'b1, 8'h01, 16'h5007, 16'h5007, n);
        probe("R3", 2'd0, 16'h5000, 8'hFF, 8'h01, 1'b1, 1'b0);
        probe("R3", 2'd0, 16'h50FF, 8'hFF, 8'h01, 1'b1, 1'b0);
        probe("R3", 2'd0, 16'h5100, 8'hFF, 8'h00, 1'b0, 1'b0);
        probe("R3", 2'd0, 16'h4FFF, 8'hFF, 8'h00, 1'b0, 1'b0);

        // R4: independent bits
        walk(1'b1, 8'h09, 16'h1240, 16'h1240, n);
        walk(1'b0, 8'h01, 16'h1240, 16'h1240, n);
        probe("R4", 2'd0, 16'h1240, 8'hFF, 8'h00, 1'b0, 1'b0);
        probe("R4", 2'd1, 16'h1240, 8'hFF, 8'h08, 1'b1, 1'b0);

        // R5 R6 R7: vector table on entry 0xDF
        walk(1'b1, 8'hDF, 16'h1250, 16'h1250, n);
        for (int i = 0; i < NVEC; i++) begin
            probe("R5/R6/R7 table", VEC[i][19:18], 16'h1250, VEC[i][17:10],
                  VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R8: temporary flag clears itself
        walk(1'b1, 8'h21, 16'h1260, 16'h1260, n);
        probe("R8", 2'd0, 16'h1260, 8'hFF, 8'h21, 1'b1, 1'b0);
        probe("R8", 2'd0, 16'h1260, 8'hFF, 8'h01, 1'b1, 1'b0);
        walk(1'b1, 8'h20, 16'h7000, 16'h7000, n);
        probe("R8", 2'd0, 16'h7010, 8'hFF, 8'h20, 1'b1, 1'b0);
        probe("R8", 2'd0, 16'h7020, 8'hFF, 8'h00, 1'b0, 1'b0);

        // R9: range walk length and coverage
        walk(1'b1, 8'h02, 16'h12F0, 16'h12FF, n);
        chk("R9 busy length", 10'(n), 10'd16);
        probe("R9", 2'd0, 16'h12F0, 8'hFF, 8'h02, 1'b1, 1'b0);
        probe("R9", 2'd0, 16'h12FF, 8'hFF, 8'h02, 1'b1, 1'b0);
        probe("R9", 2'd0, 16'h12EF, 8'hFF, 8'h00, 1'b0, 1'b0);

        // R10: reversed range ignored
        walk(1'b1, 8'h80, 16'h1280, 16'h127F, n);
        chk("R10 busy", 10'(n), 10'd0);
        probe("R10", 2'd0, 16'h1280, 8'hFF, 8'h00, 1'b0, 1'b0);
        probe("R10", 2'd0, 16'h127F, 8'hFF, 8'h00, 1'b0, 1'b0);

        // R10: start while busy ignored; R11: window write while busy ignored
        @(negedge clk);
        cfg_start = 1'b1; cfg_set = 1'b1; cfg_mask = 8'h40;
        cfg_lo = 16'h1290; cfg_hi = 16'h129F;
        @(negedge clk);
        cfg_start = 1'b0;
        @(negedge clk);
        cfg_start = 1'b1; cfg_lo = 16'h12A0; cfg_hi = 16'h12A0;
        win_we = 1'b1; win_sel = 2'd2; win_blk = 8'h50; win_on = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0; win_we = 1'b0;
        while (cfg_busy) @(negedge clk);
        probe("R10", 2'd1, 16'h12A0, 8'hFF, 8'h00, 1'b0, 1'b0);
        probe("R10", 2'd1, 16'h129F, 8'h40, 8'h40, 1'b1, 1'b0);
        probe("R11 frozen", 2'd0, 16'h5081, 8'hFF, 8'h01, 1'b1, 1'b0);

        // R11: window relocation
        set_win(2'd1, 8'h50, 1'b1);
        probe("R11", 2'd0, 16'h5000, 8'hFF, 8'h00, 1'b0, 1'b0);
        walk(1'b1, 8'h04, 16'h5080, 16'h5080, n);
        probe("R11", 2'd0, 16'h5080, 8'hFF, 8'h04, 1'b0, 1'b1);
        probe("R11", 2'd0, 16'h5081, 8'hFF, 8'h00, 1'b0, 1'b0);
        set_win(2'd1, 8'h50, 1'b0);
        probe("R11", 2'd0, 16'h5081, 8'hFF, 8'h01, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule